// File: doc/BRIEF.md
# APB Select-Line Protocol Monitor

This block watches one APB segment that has several select lines. It never drives the bus. On every clock it samples the select vector, the enable strobe, the ready strobe and the address. It follows each transfer through its setup, access and wait-state phases. When the select-line contract is broken, it sets a sticky error flag for that kind of fault.

A single registered flag vector reports the faults. The faults are:
- contention between selects;
- an access that skips its setup cycle;
- an enable that arrives late;
- a select that falls or switches before completion;
- enable held after completion;
- enable with no select;
- an address that moves during a transfer.

A combined error bit is the OR of all flags. A saturating counter tallies completed transfers. A one-cycle synchronous clear pulse zeroes the flags and the counter, so software or a test harness can mark the start of a new observation window.

Top module: `apb_select_monitor`

## Requirements
- R1: When two or more bits of `sel_i` are high in a sampled cycle, bit 0 of `err_vec` is set.
- R2: Suppose a sampled cycle has exactly one select high and `en_i` high, but the previous cycle was neither its setup cycle nor a completion. Then bit 1 of `err_vec` is set.
- R3: Take the cycle right after a setup cycle (one select high, `en_i` low). If that cycle still has the same select high with `en_i` low, bit 2 is set.
- R4: A select must stay high from its setup cycle until completion. If, during a transfer, the select vector differs from the one captured at setup (the select fell, or another select became active), bit 3 is set.
- R5: Every sampled cycle with any select high, `en_i` high and `rdy_i` high adds exactly 1 to `done_cnt`. Wait-state cycles (`rdy_i` low) add nothing.
- R6: `done_cnt` is 16 bits wide. It holds at 65535 instead of wrapping.
- R7: If `en_i` is high in the cycle right after a completion cycle, bit 4 is set.
- R8: If `en_i` is high while no bit of `sel_i` is high, bit 5 is set.
- R9: If `addr_i` differs from the address captured in the setup cycle in any later cycle of the same transfer, bit 6 is set.
- R10: Error flags stay set until a clear. A sampled `clr` forces all flags and `done_cnt` to zero on the next cycle, and it overrides any fault seen in the same cycle.
- R11: `err_any` equals the OR of the `err_vec` bits. A fault sampled at one clock edge shows on the outputs right after that edge.
- R12: These legal patterns raise no flag:
  - a setup cycle followed by an access cycle;
  - an access extended by wait states;
  - a new setup cycle directly after a completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of flags and counter |
| sel_i | input | N_SEL (4) | Observed select lines, one per target |
| en_i | input | 1 | Observed enable strobe |
| rdy_i | input | 1 | Observed ready strobe |
| addr_i | input | ADDR_W (16) | Observed address |
| err_vec | output | 7 | Sticky fault flags, bit positions as in R1 to R9 |
| err_any | output | 1 | OR of all fault flags |
| done_cnt | output | CNT_W (16) | Saturating count of completed transfers |

## Verification
The legal patterns come first: a plain two-cycle transfer, a transfer stretched by wait states, and two transfers back to back. They show that phase tracking accepts every legal timing without a false flag, and that only ready-qualified cycles add to the count. Each fault pattern is then driven on its own from a cleared state. These are a contention pair, enable without setup, a late enable, a select that drops, a select that switches, enable held after completion, enable with no select, and an address that moves. Each one must set exactly its own flag bit, which separates faults that share symptoms, such as a switch and a drop. A long run with select, enable and ready held high pushes the counter past its limit to test saturation. A clear sampled together with a contention tests the clear's priority.

// File: rtl/apb_selmon_pkg.sv
package apb_selmon_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_t;

  localparam int unsigned ERR_W = 7;

  localparam int unsigned E_CONTEND = 0;
  localparam int unsigned E_NOSETUP = 1;
  localparam int unsigned E_LATEEN  = 2;
  localparam int unsigned E_SELDROP = 3;
  localparam int unsigned E_ENHOLD  = 4;
  localparam int unsigned E_ORPHAN  = 5;
  localparam int unsigned E_ADDRMOV = 6;

endpackage

// File: rtl/sel_census.sv
module sel_census #(
  parameter int unsigned N_SEL = 4
) (
  input  logic [N_SEL-1:0] sel,
  output logic             none,
  output logic             single,
  output logic             multi
);
  localparam int unsigned CW = $clog2(N_SEL + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N_SEL; i++) begin
      ones = ones + CW'(sel[i]);
    end
  end

  assign none   = (ones == '0);
  assign single = (ones == CW'(1));
  assign multi  = (ones > CW'(1));
endmodule

// File: rtl/phase_tracker.sv
module phase_tracker
  import apb_selmon_pkg::*;
#(
  parameter int unsigned N_SEL  = 4,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SEL-1:0]  sel,
  input  logic              en,
  input  logic              rdy,
  input  logic [ADDR_W-1:0] addr,
  input  logic              single,
  output logic              fin,
  output logic              v_nosetup,
  output logic              v_late,
  output logic              v_drop,
  output logic              v_hold,
  output logic              v_addr
);
  phase_t             ph, ph_nxt;
  logic [N_SEL-1:0]   sel_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               done_q;
  logic               cap;
  logic               same;

  assign fin    = (|sel) & en & rdy;
  assign same   = (sel == sel_q);
  assign v_hold = done_q & en;

  always_comb begin
    ph_nxt    = ph;
    cap       = 1'b0;
    v_nosetup = 1'b0;
    v_late    = 1'b0;
    v_drop    = 1'b0;
    v_addr    = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        if (single && !en) begin
          ph_nxt = PH_SETUP;
          cap    = 1'b1;
        end else if (single && en && !done_q) begin
          v_nosetup = 1'b1;
        end
      end
      PH_SETUP: begin
        if (!same) begin
          v_drop = 1'b1;
          ph_nxt = PH_IDLE;
        end else begin
          v_addr = (addr != addr_q);
          if (!en) begin
            v_late = 1'b1;
            cap    = 1'b1;
          end else if (rdy) begin
            ph_nxt = PH_IDLE;
          end else begin
            ph_nxt = PH_ACCESS;
          end
        end
      end
      PH_ACCESS: begin
        if (!same) begin
          v_drop = 1'b1;
          ph_nxt = PH_IDLE;
        end else begin
          v_addr = (addr != addr_q);
          if (!en || rdy) begin
            ph_nxt = PH_IDLE;
          end
        end
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      sel_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      ph     <= ph_nxt;
      done_q <= fin;
      if (cap) begin
        sel_q  <= sel;
        addr_q <= addr;
      end
    end
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] flags,
  output logic         any
);
  logic [W-1:0] nxt;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign nxt[g] = flags[g] | set[g];
    always_ff @(posedge clk) begin
      if (rst || clr) flags[g] <= 1'b0;
      else            flags[g] <= nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) any <= 1'b0;
    else            any <= |nxt;
  end
endmodule

// File: rtl/done_counter.sv
module done_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/apb_select_monitor.sv
module apb_select_monitor
  import apb_selmon_pkg::*;
#(
  parameter int unsigned N_SEL  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [N_SEL-1:0]  sel_i,
  input  logic              en_i,
  input  logic              rdy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ERR_W-1:0]  err_vec,
  output logic              err_any,
  output logic [CNT_W-1:0]  done_cnt
);
  logic             none, single, multi;
  logic             fin;
  logic             v_nosetup, v_late, v_drop, v_hold, v_addr;
  logic [ERR_W-1:0] hits;

  sel_census #(.N_SEL(N_SEL)) u_census (
    .sel    (sel_i),
    .none   (none),
    .single (single),
    .multi  (multi)
  );

  phase_tracker #(.N_SEL(N_SEL), .ADDR_W(ADDR_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel_i),
    .en        (en_i),
    .rdy       (rdy_i),
    .addr      (addr_i),
    .single    (single),
    .fin       (fin),
    .v_nosetup (v_nosetup),
    .v_late    (v_late),
    .v_drop    (v_drop),
    .v_hold    (v_hold),
    .v_addr    (v_addr)
  );

  always_comb begin
    hits            = '0;
    hits[E_CONTEND] = multi;
    hits[E_NOSETUP] = v_nosetup;
    hits[E_LATEEN]  = v_late;
    hits[E_SELDROP] = v_drop;
    hits[E_ENHOLD]  = v_hold;
    hits[E_ORPHAN]  = none & en_i;
    hits[E_ADDRMOV] = v_addr;
  end

  sticky_flags #(.W(ERR_W)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .set   (hits),
    .flags (err_vec),
    .any   (err_any)
  );

  done_counter #(.CNT_W(CNT_W)) u_count (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .inc (fin),
    .cnt (done_cnt)
  );
endmodule

// File: rtl/apb_selmon_checker.sv
module apb_selmon_checker #(
  parameter int unsigned N_SEL = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic [N_SEL-1:0] sel_i,
  input logic             en_i,
  input logic             rdy_i,
  input logic [6:0]       err_vec,
  input logic             err_any,
  input logic [CNT_W-1:0] done_cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_CONTENTION_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!clr && $countones(sel_i) > 1) |=> err_vec[0]); // R1

  AST_ORPHAN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!clr && en_i && sel_i == '0) |=> err_vec[5]); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((err_vec & $past(err_vec)) == $past(err_vec))); // R10

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (err_vec == '0 && done_cnt == '0)); // R10

  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (rst)
    err_any == (|err_vec)); // R11

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && done_cnt != TOP && (|sel_i) && en_i && rdy_i)
      |=> done_cnt == $past(done_cnt) + CNT_W'(1)); // R5

  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !((|sel_i) && en_i && rdy_i)) |=> $stable(done_cnt)); // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr && done_cnt == TOP) |=> done_cnt == TOP); // R6
endmodule

bind apb_select_monitor apb_selmon_checker #(.N_SEL(N_SEL), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .sel_i    (sel_i),
  .en_i     (en_i),
  .rdy_i    (rdy_i),
  .err_vec  (err_vec),
  .err_any  (err_any),
  .done_cnt (done_cnt)
);

// File: tb/apb_select_monitor_bench.sv
`timescale 1ns/1ps
module apb_select_monitor_bench;
  localparam int unsigned N_SEL  = 4;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clr = 1'b0;
  logic [N_SEL-1:0]  sel_i = '0;
  logic              en_i = 1'b0;
  logic              rdy_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [6:0]        err_vec;
  logic              err_any;
  logic [CNT_W-1:0]  done_cnt;

  typedef struct {
    string       tag;
    logic [6:0]  vec;
    logic [15:0] cnt;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  apb_select_monitor #(.N_SEL(N_SEL), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_apb_select_monitor (
    .clk(clk), .rst(rst), .clr(clr), .sel_i(sel_i), .en_i(en_i), .rdy_i(rdy_i),
    .addr_i(addr_i), .err_vec(err_vec), .err_any(err_any), .done_cnt(done_cnt)
  );

  task automatic cyc(input logic [3:0] s, input logic e, input logic r,
                     input logic [15:0] a, input logic c = 1'b0);
    @(negedge clk);
    sel_i = s; en_i = e; rdy_i = r; addr_i = a; clr = c;
  endtask

  task automatic expect_out(input string tag, input logic [6:0] v, input logic [15:0] n);
    exp_t it;
    it.tag = tag; it.vec = v; it.cnt = n;
    q.push_back(it);
  endtask

  task automatic idle(input logic c = 1'b0);
    cyc(4'b0000, 1'b0, 1'b0, 16'h0000, c);
  endtask

  // monitor: compare right after the edge that samples the last driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        n_cmp++;
        if (err_vec !== it.vec || done_cnt !== it.cnt || err_any !== (it.vec != 0)) begin
          n_bad++;
          $display("FAIL %s: got vec=%h any=%b cnt=%0d, want vec=%h any=%b cnt=%0d",
                   it.tag, err_vec, err_any, done_cnt, it.vec, (it.vec != 0), it.cnt);
        end
      end
    end
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(); expect_out("reset R10 R11", 7'h00, 16'd0);

    // R12 R5: plain transfer
    cyc(4'b0001, 1'b0, 1'b0, 16'h1000);
    cyc(4'b0001, 1'b1, 1'b1, 16'h1000); expect_out("R12 R5 plain", 7'h00, 16'd1);
    idle();
    // R12 R5: wait states counted once
    cyc(4'b0100, 1'b0, 1'b0, 16'h2004);
    cyc(4'b0100, 1'b1, 1'b0, 16'h2004); expect_out("R5 wait1", 7'h00, 16'd1);
    cyc(4'b0100, 1'b1, 1'b0, 16'h2004);
    cyc(4'b0100, 1'b1, 1'b1, 16'h2004); expect_out("R12 R5 wait done", 7'h00, 16'd2);
    // R12: back to back
    cyc(4'b0010, 1'b0, 1'b0, 16'h3000);
    cyc(4'b0010, 1'b1, 1'b1, 16'h3000);
    cyc(4'b1000, 1'b0, 1'b0, 16'h4000);
    cyc(4'b1000, 1'b1, 1'b1, 16'h4000); expect_out("R12 back-to-back", 7'h00, 16'd4);
    idle();

    // R1 contention, R10 sticky, R10 clear priority
    cyc(4'b0011, 1'b0, 1'b0, 16'h0000); expect_out("R1 contention", 7'h01, 16'd4);
    idle();                              expect_out("R10 sticky", 7'h01, 16'd4);
    cyc(4'b0011, 1'b0, 1'b0, 16'h0000, 1'b1); expect_out("R10 clear wins", 7'h00, 16'd0);
    idle();

    // R2 enable without setup
    cyc(4'b0001, 1'b1, 1'b0, 16'h1000); expect_out("R2 no setup", 7'h02, 16'd0);
    idle(1'b1); idle();

    // R3 late enable, then finish
    cyc(4'b0001, 1'b0, 1'b0, 16'h1000);
    cyc(4'b0001, 1'b0, 1'b0, 16'h1000); expect_out("R3 late enable", 7'h04, 16'd0);
    cyc(4'b0001, 1'b1, 1'b1, 16'h1000); expect_out("R3 late then done", 7'h04, 16'd1);
    idle(1'b1); idle();

    // R4 select drops during wait
    cyc(4'b0100, 1'b0, 1'b0, 16'h2000);
    cyc(4'b0100, 1'b1, 1'b0, 16'h2000);
    cyc(4'b0000, 1'b0, 1'b0, 16'h2000); expect_out("R4 drop", 7'h08, 16'd0);
    idle(1'b1); idle();
    // R4 select switches
    cyc(4'b0001, 1'b0, 1'b0, 16'h1000);
    cyc(4'b0010, 1'b1, 1'b0, 16'h1000); expect_out("R4 switch", 7'h08, 16'd0);
    idle(1'b1); idle();

    // R7 enable held after completion
    cyc(4'b0001, 1'b0, 1'b0, 16'h1000);
    cyc(4'b0001, 1'b1, 1'b1, 16'h1000);
    cyc(4'b0001, 1'b1, 1'b0, 16'h1000); expect_out("R7 enable hold", 7'h10, 16'd1);
    idle(1'b1); idle();

    // R8 enable with no select
    cyc(4'b0000, 1'b1, 1'b0, 16'h0000); expect_out("R8 orphan enable", 7'h20, 16'd0);
    idle(1'b1); idle();

    // R9 address moves in access
    cyc(4'b0010, 1'b0, 1'b0, 16'h5000);
    cyc(4'b0010, 1'b1, 1'b0, 16'h5008); expect_out("R9 addr move", 7'h40, 16'd0);
    cyc(4'b0010, 1'b1, 1'b1, 16'h5000); expect_out("R9 addr then done", 7'h40, 16'd1);
    idle(1'b1); idle();

    // R6 saturation: 65537 completing cycles in a row (R2 first, R7 after)
    for (int i = 0; i < 65537; i++) begin
      cyc(4'b0001, 1'b1, 1'b1, 16'h1000);
    end
    expect_out("R6 saturate", 7'h12, 16'hFFFF);
    idle(); expect_out("R6 hold max", 7'h12, 16'hFFFF);
    idle(1'b1); expect_out("R10 clear count", 7'h00, 16'd0);

    idle(); idle(); idle();
    done = 1'b1;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL drain: got %0d pending, want 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule